// File: doc/BRIEF.md
# Interrupt and Field Control Unit

This unit holds the status flags of a 12-bit word processor. It executes the small group of instructions that turn interrupts on and off, test the interrupt state, save and restore the flags, and change the data field. The instruction decoder presents a 3-bit function code with a strobe. The datapath presents the accumulator, the link and the already incremented next PC. The unit returns a next PC that may be advanced by one, plus accumulator and link results with write enables. The updated flags, the saved copy and the arming state are available as registered outputs.

Each instruction completion is marked by a retire strobe. This strobe is the instruction boundary. At a boundary the unit promotes a pending interrupt enable and decides whether an interrupt is taken. A taken interrupt copies the live flags into the saved register, drops the enable and raises a one-cycle accept pulse. Turning interrupts on, whether by the enable instruction or by a flags restore, only arms a delay. The enable itself appears one completed instruction later, so a return sequence finishes before another interrupt can enter.

Flag layout (11 bits): bit 10 greater-than, bit 9 request, bit 8 inhibit, bit 7 enable, bit 6 user mode, bits 5:3 instruction field, bits 2:0 data field.

Function codes: 0 skip-if-enabled, 1 enable, 2 disable, 3 skip-if-request, 4 get flags, 5 restore flags, 6 set data field, 7 no operation.

Top module: `ifc_ctrl_unit`

## Requirements
- R1: A synchronous active-high reset clears the flags, the saved flags, the arming bit and the accept pulse to zero.
- R2: Function 0 returns next PC plus one, modulo 4096, when flag bit 7 is set; otherwise it returns the next PC unchanged.
- R3: Function 3 returns next PC plus one, modulo 4096, when flag bit 9 is set; otherwise it returns the next PC unchanged.
- R4: Function 1 sets the arming bit at its own boundary and leaves bit 7 and every other flag unchanged.
- R5: At a boundary where the arming bit was already set and the current instruction did not arm it, bit 7 becomes 1 and the arming bit clears.
- R6: Function 2 clears bit 7 and the arming bit, keeps all other flags, and no promotion follows.
- R7: Function 4 drives the accumulator result as {link, saved flags[10:0]} with its write enable high.
- R8: Function 5 writes the link from accumulator bit 11 and loads the flags from accumulator bits 10:0. If accumulator bit 7 is set, the arming bit is set, and bit 7 is kept only when the live enable was already 1. If accumulator bit 7 is clear, the arming bit clears.
- R9: Function 6 replaces flag bits 2:0 with the 3-bit field input and keeps the other flags.
- R10: At a boundary where, after the instruction and any promotion, bit 7 and bit 9 are set, bit 8 is clear and the arming bit is clear, the unit copies those flags into the saved register and clears bit 7. It then pulses the accept output for exactly one cycle.
- R11: Flag bit 9 follows the interrupt request input with one register delay; a restore never changes it.
- R12: Function 7, and any function strobed without retire, changes no flag and raises no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction boundary strobe |
| op_valid_i | input | 1 | Current retiring instruction belongs to this unit |
| op_fn_i | input | 3 | Function code |
| field_i | input | 3 | Data field for function 6 |
| acc_i | input | 12 | Accumulator value |
| link_i | input | 1 | Link value |
| npc_i | input | 12 | Incremented program counter |
| irq_i | input | 1 | Interrupt request level |
| flags_o | output | 11 | Live flags |
| saved_o | output | 11 | Saved flags |
| arm_o | output | 1 | Enable arming bit |
| npc_o | output | 12 | Next PC after any skip |
| acc_o | output | 12 | Accumulator result |
| acc_we_o | output | 1 | Accumulator write enable |
| link_o | output | 1 | Link result |
| link_we_o | output | 1 | Link write enable |
| int_accept_o | output | 1 | One-cycle interrupt accept pulse |

## Verification
The bench builds the unit with its default program counter width of 12. This puts the skip wrap from 0xFFF to 0x000 within reach of a single directed step. It drives enable, restore and inhibit sequences in an order that reaches all three restore outcomes while a request is pending. It checks that the arming delay holds off acceptance for exactly one boundary in each case.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    localparam int WORD_W  = 12;
    localparam int FLAG_W  = WORD_W - 1;
    localparam int FIELD_W = 3;

    localparam int BIT_GT  = 10;
    localparam int BIT_REQ = 9;
    localparam int BIT_INH = 8;
    localparam int BIT_EN  = 7;
    localparam int BIT_USR = 6;
    localparam int IF_LO   = 3;
    localparam int DF_LO   = 0;

    typedef enum logic [2:0] {
        FN_SKIP_EN  = 3'd0,
        FN_ION      = 3'd1,
        FN_IOF      = 3'd2,
        FN_SKIP_REQ = 3'd3,
        FN_GET      = 3'd4,
        FN_RESTORE  = 3'd5,
        FN_SET_DF   = 3'd6,
        FN_NONE     = 3'd7
    } ifc_fn_e;

    typedef logic [FLAG_W-1:0] flags_t;

    typedef struct packed {
        flags_t flags;
        flags_t saved;
        logic   arm;
        logic   accept;
    } ifc_state_t;
endpackage

// File: rtl/ifc_skip_adder.sv
module ifc_skip_adder #(
    parameter int W = 12
) (
    input  logic [W-1:0] pc_i,
    input  logic         skip_i,
    output logic [W-1:0] pc_o
);
    // Sum is truncated to W bits, which gives the modulo wrap.
    assign pc_o = pc_i + W'(skip_i);
endmodule

// File: rtl/ifc_op_exec.sv
module ifc_op_exec
    import ifc_pkg::*;
(
    input  logic                op_sel_i,
    input  ifc_fn_e             fn_i,
    input  flags_t              flags_i,
    input  flags_t              saved_i,
    input  logic                arm_i,
    input  logic [WORD_W-1:0]   acc_i,
    input  logic                link_i,
    input  logic [FIELD_W-1:0]  field_i,
    output flags_t              flags_o,
    output logic                arm_o,
    output logic                armed_now_o,
    output logic                skip_o,
    output logic [WORD_W-1:0]   acc_o,
    output logic                acc_we_o,
    output logic                link_o,
    output logic                link_we_o
);
    always_comb begin
        flags_o     = flags_i;
        arm_o       = arm_i;
        armed_now_o = 1'b0;
        skip_o      = 1'b0;
        acc_o       = '0;
        acc_we_o    = 1'b0;
        link_o      = 1'b0;
        link_we_o   = 1'b0;
        if (op_sel_i) begin
            unique case (fn_i)
                FN_SKIP_EN:  skip_o = flags_i[BIT_EN];
                FN_SKIP_REQ: skip_o = flags_i[BIT_REQ];
                FN_ION: begin
                    arm_o       = 1'b1;
                    armed_now_o = 1'b1;
                end
                FN_IOF: begin
                    flags_o[BIT_EN] = 1'b0;
                    arm_o           = 1'b0;
                end
                FN_GET: begin
                    acc_o    = {link_i, saved_i};
                    acc_we_o = 1'b1;
                end
                FN_RESTORE: begin
                    flags_o   = acc_i[FLAG_W-1:0];
                    link_o    = acc_i[WORD_W-1];
                    link_we_o = 1'b1;
                    if (acc_i[BIT_EN]) begin
                        arm_o       = 1'b1;
                        armed_now_o = 1'b1;
                        if (!flags_i[BIT_EN]) flags_o[BIT_EN] = 1'b0;
                    end else begin
                        arm_o = 1'b0;
                    end
                end
                FN_SET_DF: flags_o[DF_LO +: FIELD_W] = field_i;
                default: ;
            endcase
            // The request bit is owned by the input pin, never by software.
            flags_o[BIT_REQ] = flags_i[BIT_REQ];
        end
    end
endmodule

// File: rtl/ifc_boundary.sv
module ifc_boundary
    import ifc_pkg::*;
(
    input  logic   retire_i,
    input  flags_t flags_i,
    input  logic   arm_i,
    input  logic   armed_now_i,
    output flags_t flags_o,
    output flags_t capture_o,
    output logic   arm_o,
    output logic   accept_o
);
    logic   promote;
    flags_t staged;

    always_comb begin
        promote = retire_i && arm_i && !armed_now_i;
        staged  = flags_i;
        arm_o   = arm_i;
        if (promote) begin
            staged[BIT_EN] = 1'b1;
            arm_o          = 1'b0;
        end
        accept_o  = retire_i && staged[BIT_EN] && staged[BIT_REQ]
                    && !staged[BIT_INH] && !arm_o;
        capture_o = staged;
        flags_o   = staged;
        if (accept_o) flags_o[BIT_EN] = 1'b0;
    end
endmodule

// File: rtl/ifc_ctrl_unit.sv
module ifc_ctrl_unit
    import ifc_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 retire_i,
    input  logic                 op_valid_i,
    input  logic [2:0]           op_fn_i,
    input  logic [FIELD_W-1:0]   field_i,
    input  logic [WORD_W-1:0]    acc_i,
    input  logic                 link_i,
    input  logic [PC_W-1:0]      npc_i,
    input  logic                 irq_i,
    output logic [FLAG_W-1:0]    flags_o,
    output logic [FLAG_W-1:0]    saved_o,
    output logic                 arm_o,
    output logic [PC_W-1:0]      npc_o,
    output logic [WORD_W-1:0]    acc_o,
    output logic                 acc_we_o,
    output logic                 link_o,
    output logic                 link_we_o,
    output logic                 int_accept_o
);
    ifc_state_t st_d, st_q;
    ifc_fn_e    fn;
    logic       op_sel;
    flags_t     op_flags, bnd_flags, bnd_capture;
    logic       op_arm, op_armed_now, op_skip;
    logic       bnd_arm, bnd_accept;

    assign fn     = ifc_fn_e'(op_fn_i);
    assign op_sel = retire_i && op_valid_i;

    ifc_op_exec u_exec (
        .op_sel_i    (op_sel),
        .fn_i        (fn),
        .flags_i     (st_q.flags),
        .saved_i     (st_q.saved),
        .arm_i       (st_q.arm),
        .acc_i       (acc_i),
        .link_i      (link_i),
        .field_i     (field_i),
        .flags_o     (op_flags),
        .arm_o       (op_arm),
        .armed_now_o (op_armed_now),
        .skip_o      (op_skip),
        .acc_o       (acc_o),
        .acc_we_o    (acc_we_o),
        .link_o      (link_o),
        .link_we_o   (link_we_o)
    );

    ifc_boundary u_bnd (
        .retire_i    (retire_i),
        .flags_i     (op_flags),
        .arm_i       (op_arm),
        .armed_now_i (op_armed_now),
        .flags_o     (bnd_flags),
        .capture_o   (bnd_capture),
        .arm_o       (bnd_arm),
        .accept_o    (bnd_accept)
    );

    ifc_skip_adder #(.W(PC_W)) u_skip (
        .pc_i   (npc_i),
        .skip_i (op_skip),
        .pc_o   (npc_o)
    );

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        if (retire_i) begin
            st_d.flags  = bnd_flags;
            st_d.arm    = bnd_arm;
            st_d.accept = bnd_accept;
            if (bnd_accept) st_d.saved = bnd_capture;
        end
        st_d.flags[BIT_REQ] = irq_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign flags_o      = st_q.flags;
    assign saved_o      = st_q.saved;
    assign arm_o        = st_q.arm;
    assign int_accept_o = st_q.accept;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (flags_o == '0 && saved_o == '0 && !arm_o && !int_accept_o));

    // R2
    skip_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_sel && fn == FN_SKIP_EN && !flags_o[BIT_EN]) |-> npc_o == npc_i);

    // R4
    ion_arm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_sel && fn == FN_ION) |=> (arm_o && flags_o[BIT_EN] == $past(flags_o[BIT_EN])));

    // R6
    iof_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_sel && fn == FN_IOF) |=> (!flags_o[BIT_EN] && !arm_o));

    // R10
    accept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        int_accept_o |-> (saved_o[BIT_EN] && saved_o[BIT_REQ] && !saved_o[BIT_INH]
                          && !flags_o[BIT_EN] && !arm_o));

    // R10
    accept_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        int_accept_o |=> !int_accept_o);

    // R11
    req_mirror_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> flags_o[BIT_REQ] == $past(irq_i));

    // R12
    nop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_sel && fn == FN_NONE) |-> (!acc_we_o && !link_we_o && npc_o == npc_i));
endmodule

// File: tb/sim_ifc_ctrl_unit.sv
module sim_ifc_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ret = 1'b0, opv = 1'b0, lnk = 1'b0, irq = 1'b0;
    logic [2:0]  fn = '0, fld = '0;
    logic [11:0] acc = '0, npc = '0;
    logic [10:0] flags, saved;
    logic        arm, acc_we, link_o, link_we, accept;
    logic [11:0] npc_o, acc_o;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ifc_ctrl_unit u0 (
        .clk_i(clk), .rst_i(rst), .retire_i(ret), .op_valid_i(opv), .op_fn_i(fn),
        .field_i(fld), .acc_i(acc), .link_i(lnk), .npc_i(npc), .irq_i(irq),
        .flags_o(flags), .saved_o(saved), .arm_o(arm), .npc_o(npc_o), .acc_o(acc_o),
        .acc_we_o(acc_we), .link_o(link_o), .link_we_o(link_we), .int_accept_o(accept)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [2:0] f, input logic o, input logic r,
                       input logic [11:0] a, input logic l, input logic [11:0] p,
                       input logic [2:0] d);
        fn = f; opv = o; ret = r; acc = a; lnk = l; npc = p; fld = d;
        #2;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        opv = 1'b0; ret = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 flags", flags, 0);
        chk("R1 saved", saved, 0);
        chk("R1 arm", arm, 0);
        chk("R1 accept", accept, 0);
    endtask

    task automatic t_ion();
        put(3'd1, 1, 1, 0, 0, 0, 0); tick();
        chk("R4 enable untouched", flags, 11'h000);
        chk("R4 armed", arm, 1);
        put(3'd0, 0, 1, 0, 0, 0, 0); tick();
        chk("R5 promoted", flags, 11'h080);
        chk("R5 arm cleared", arm, 0);
    endtask

    task automatic t_skip();
        put(3'd0, 1, 1, 0, 0, 12'hFFF, 0);
        chk("R2 skip wraps", npc_o, 12'h000);
        tick();
        put(3'd3, 1, 1, 0, 0, 12'h010, 0);
        chk("R3 no request no skip", npc_o, 12'h010);
        tick();
    endtask

    task automatic t_field();
        put(3'd6, 1, 1, 0, 0, 0, 3'd5); tick();
        chk("R9 data field", flags, 11'h085);
        put(3'd7, 1, 1, 12'hFFF, 1, 12'h100, 3'd7);
        chk("R12 nop pc", npc_o, 12'h100);
        chk("R12 nop acc we", acc_we, 0);
        chk("R12 nop link we", link_we, 0);
        tick();
        chk("R12 nop flags", flags, 11'h085);
        put(3'd2, 1, 0, 0, 0, 0, 0); tick();
        chk("R12 no retire", flags, 11'h085);
    endtask

    task automatic t_iof();
        put(3'd2, 1, 1, 0, 0, 0, 0); tick();
        chk("R6 off", flags, 11'h005);
        put(3'd0, 1, 1, 0, 0, 12'h123, 0);
        chk("R2 disabled no skip", npc_o, 12'h123);
        tick();
        put(3'd1, 1, 1, 0, 0, 0, 0); tick();
        put(3'd2, 1, 1, 0, 0, 0, 0); tick();
        chk("R6 arm dropped", arm, 0);
        put(3'd0, 0, 1, 0, 0, 0, 0); tick();
        chk("R6 no promotion", flags, 11'h005);
    endtask

    task automatic t_accept();
        irq = 1'b1;
        put(3'd0, 0, 0, 0, 0, 0, 0); tick();
        chk("R11 request mirrored", flags, 11'h205);
        put(3'd3, 1, 1, 0, 0, 12'h020, 0);
        chk("R3 request skip", npc_o, 12'h021);
        tick();
        put(3'd1, 1, 1, 0, 0, 0, 0); tick();
        chk("R10 held by arm", accept, 0);
        put(3'd0, 0, 1, 0, 0, 0, 0); tick();
        chk("R10 accept", accept, 1);
        chk("R10 saved", saved, 11'h285);
        chk("R10 enable dropped", flags, 11'h205);
        put(3'd0, 0, 0, 0, 0, 0, 0); tick();
        chk("R10 single pulse", accept, 0);
    endtask

    task automatic t_get();
        put(3'd4, 1, 1, 0, 1, 0, 0);
        chk("R7 acc result", acc_o, 12'hA85);
        chk("R7 acc we", acc_we, 1);
        tick();
    endtask

    task automatic t_restore();
        put(3'd5, 1, 1, 12'h183, 0, 0, 0);
        chk("R8 link value", link_o, 0);
        chk("R8 link we", link_we, 1);
        tick();
        chk("R8 enable withheld", flags, 11'h303);
        chk("R8 armed", arm, 1);
        put(3'd0, 0, 1, 0, 0, 0, 0); tick();
        chk("R10 inhibit blocks", accept, 0);
        chk("R5 promote after restore", flags, 11'h383);
        put(3'd5, 1, 1, 12'h882, 0, 0, 0);
        chk("R8 link from acc", link_o, 1);
        tick();
        chk("R8 enable kept", flags, 11'h282);
        chk("R10 no reentry", accept, 0);
        put(3'd0, 0, 1, 0, 0, 0, 0); tick();
        chk("R10 accept after return", accept, 1);
        chk("R10 saved after return", saved, 11'h282);
        put(3'd5, 1, 1, 12'h401, 0, 0, 0); tick();
        chk("R8 plain restore", flags, 11'h601);
        chk("R8 plain arm clear", arm, 0);
        irq = 1'b0;
        put(3'd0, 0, 0, 0, 0, 0, 0); tick();
        chk("R11 request falls", flags, 11'h401);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ion();
        t_skip();
        t_field();
        t_iof();
        t_accept();
        t_get();
        t_restore();
        summary();
    end

    initial begin
        #4000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule